// File: doc/BRIEF.md
# Programmable interrupt source router

The block takes 32 level-sensitive peripheral interrupt lines and steers each one onto one of a small set of parent interrupt outputs. Software programs a 4-bit destination code per source, a global enable mask and can read the current synchronised input levels. An output is asserted while at least one enabled, active source is steered to it. The block neither acknowledges nor prioritises. The parent controller alone decides which of its inputs to serve first.

Registers are accessed through a simple 32-bit read/write port with word addresses. The register window holds eight words. Word 0 (byte 0x00) is the enable mask. Word 1 (byte 0x04) is the read-only level status. Words 2 to 5 (bytes 0x08 to 0x14) are the four destination words. Words 6 and 7 are unused. The destination words are stored in reverse order: the lowest-addressed word holds the highest-numbered sources.

Top module: `irq_route_top`

## Requirements
- R1: After reset the mask word and all four destination words read zero, and every bit of `irq_o` is 0.
- R2: A write to word 0 stores all 32 bits of `wdata_i` as the enable mask. Bit n enables source n, and a read of word 0 returns the stored value.
- R3: Word 1 returns `src_i` delayed by two clock edges. It is read-only: a write to it changes neither the mask nor any destination word.
- R4: Destination word 2+j (j = 0..3) holds the codes of sources 8*(3-j) to 8*(3-j)+7. Word 2 therefore holds sources 24 to 31, and word 5 holds sources 0 to 7. Each word reads back the value last written to it.
- R5: Within a destination word, the code of source n occupies bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R6: A destination code of 0 connects the source to no output.
- R7: A code k with 1 <= k <= N_OUT steers the source to `irq_o[k-1]`. A code above N_OUT (7 to 15 in the default build of 6 outputs) drives no output.
- R8: A source takes part in routing only when its mask bit and its status bit are both 1.
- R9: `irq_o[i]` is the OR over all pending sources whose code is i+1. It stays high while any one of them remains active.
- R10: `irq_o` reflects a mask or destination write one clock edge after the edge that stores it. It reflects a change on `src_i` three edges after the change: two synchroniser edges plus one output register.
- R11: Writes to words 6 and 7 change no register, and reads of those words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources, one bit per source |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | N_OUT | Registered parent interrupt outputs |

## Verification
A register write and a change in source levels can reach the output register in the same cycle. Changing one field of a destination word can also move one source away from an output while another source still holds that output high. The bench provokes both overlaps. In random rounds it writes mask or destination words while it changes `src_i`, and in directed cases it drops one of two sources that share an output. After each step it compares `irq_o` and the status word with values computed from its own model of mask, codes and levels. Directed timing cases sample the output on the edge before the expected update and on the edge of the update.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NSRC            = 32;
  localparam int unsigned CODE_W          = 4;
  localparam int unsigned WORD_W          = 32;
  localparam int unsigned ADDR_W          = 3;
  localparam int unsigned FIELDS_PER_WORD = WORD_W / CODE_W;
  localparam int unsigned ROUTE_WORDS     = NSRC / FIELDS_PER_WORD;
  localparam int unsigned MAX_OUT         = (1 << CODE_W) - 1;

  localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_RT0  = 3'd2;

  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/irq_route_sync.sv
module irq_route_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  input  logic [NSRC-1:0]               status_i,
  output logic [WORD_W-1:0]             rdata_o,
  output logic [NSRC-1:0]               mask_o,
  output logic [NSRC-1:0][CODE_W-1:0]   route_o
);
  logic [WORD_W-1:0]      mask_q;
  logic [WORD_W-1:0]      rt_q [ROUTE_WORDS];
  logic [ROUTE_WORDS-1:0] rt_we;
  logic                   mask_we;

  assign mask_we = req_i && we_i && (addr_i == A_MASK);

  for (genvar j = 0; j < ROUTE_WORDS; j++) begin : g_we
    assign rt_we[j] = req_i && we_i && (addr_i == A_RT0 + ADDR_W'(j));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int j = 0; j < ROUTE_WORDS; j++) rt_q[j] <= '0;
    end else begin
      if (mask_we) mask_q <= wdata_i;
      for (int j = 0; j < ROUTE_WORDS; j++)
        if (rt_we[j]) rt_q[j] <= wdata_i;
    end
  end

  // reversed packing: highest sources live in the lowest word
  for (genvar n = 0; n < NSRC; n++) begin : g_field
    localparam int unsigned WI = ROUTE_WORDS - 1 - n / FIELDS_PER_WORD;
    localparam int unsigned LO = CODE_W * (n % FIELDS_PER_WORD);
    assign route_o[n] = rt_q[WI][LO +: CODE_W];
  end

  assign mask_o = mask_q[NSRC-1:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MASK) rdata_o = mask_q;
    else if (addr_i == A_STAT) rdata_o = status_i;
    else begin
      for (int j = 0; j < ROUTE_WORDS; j++)
        if (addr_i == A_RT0 + ADDR_W'(j)) rdata_o = rt_q[j];
    end
  end

  // R2
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_MASK) |=> (mask_o == $past(wdata_i)));

  // R3
  stat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_STAT) |=> ($stable(mask_o) && $stable(route_o)));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i >= A_RT0 + ADDR_W'(ROUTE_WORDS))
      |=> ($stable(mask_o) && $stable(route_o)));
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irq_route_pkg::*;
#(
  parameter int unsigned N_OUT = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NSRC-1:0]             mask_i,
  input  logic [NSRC-1:0]             status_i,
  input  logic [NSRC-1:0][CODE_W-1:0] route_i,
  output logic [N_OUT-1:0]            irq_o
);
  logic [NSRC-1:0]  pend;
  logic [N_OUT-1:0] hit;
  logic [N_OUT-1:0] irq_q;

  assign pend = mask_i & status_i;

  // code 0 and codes above N_OUT never match an output index
  always_comb begin
    hit = '0;
    for (int o = 0; o < N_OUT; o++)
      for (int n = 0; n < NSRC; n++)
        if (pend[n] && route_i[n] == CODE_W'(o + 1)) hit[o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end

  assign irq_o = irq_q;

  // R8
  no_pend_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |=> (irq_o == '0));

  // R6
  all_disc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int unsigned N_OUT       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSRC-1:0]       src_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic [N_OUT-1:0]      irq_o
);
  logic [NSRC-1:0]             status;
  logic [NSRC-1:0]             mask;
  logic [NSRC-1:0][CODE_W-1:0] route;

  irq_route_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (status)
  );

  irq_route_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status),
    .rdata_o (rdata_o),
    .mask_o  (mask),
    .route_o (route)
  );

  irq_route_xbar #(.N_OUT(N_OUT)) u_xbar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mask_i  (mask),
    .status_i(status),
    .route_i (route),
    .irq_o   (irq_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/tb_irq_route_top.sv
`timescale 1ns/1ps
module tb_irq_route_top;
  localparam int NOUT = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NOUT-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mask_m = '0;
  logic [3:0]  code_m [32];

  always #4 clk = ~clk;

  irq_route_top #(.N_OUT(NOUT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [NOUT-1:0] exp_irq();
    logic [NOUT-1:0] e = '0;
    for (int n = 0; n < 32; n++)
      if (mask_m[n] && src_i[n] && code_m[n] >= 1 && code_m[n] <= NOUT)
        e[code_m[n]-1] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] exp_word(int j);
    logic [31:0] w = '0;
    for (int m = 0; m < 8; m++) w[4*m +: 4] = code_m[8*(3-j) + m];
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
    if (a == 3'd0) mask_m = d;
    else if (a >= 3'd2 && a <= 3'd5)
      for (int m = 0; m < 8; m++) code_m[8*(3-(a-2)) + m] = d[4*m +: 4];
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_irq(string tag);
    chk(tag, 32'(irq_o), 32'(exp_irq()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int n = 0; n < 32; n++) code_m[n] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 mask", d, 0);
    for (int j = 0; j < 4; j++) begin rd(3'(2+j), d); chk("R1 route", d, 0); end
    chk("R1 irq", 32'(irq_o), 0);

    // R2 mask readback
    wr(3'd0, 32'hA5C3_0F81); rd(3'd0, d); chk("R2 mask rb", d, 32'hA5C3_0F81);

    // R3 status and read-only
    src_i = 32'h1234_5678;
    @(negedge clk); rd(3'd1, d); chk("R3 status early", d, 0);
    @(negedge clk); rd(3'd1, d); chk("R3 status", d, 32'h1234_5678);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd0, d); chk("R3 ro mask", d, 32'hA5C3_0F81);
    rd(3'd1, d); chk("R3 ro status", d, 32'h1234_5678);

    // R4 R5 reversed packing: src31 top nibble of word 2, src0 low nibble of word 5
    src_i = 32'h8000_0001; wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'h1000_0000); wr(3'd5, 32'h0000_0002);
    settle(); chk("R4 R5 pack", 32'(irq_o), 32'b11);
    rd(3'd2, d); chk("R4 rb w2", d, 32'h1000_0000);
    rd(3'd5, d); chk("R4 rb w5", d, 32'h0000_0002);
    // R5 middle field: source 13 is word 4, bits 23:20
    src_i = 32'h0000_2000; wr(3'd4, 32'h0040_0000); settle();
    chk("R5 src13", 32'(irq_o), 32'b1000);

    // R6 code zero
    wr(3'd4, 32'h0); settle(); chk("R6 disc", 32'(irq_o), 0);

    // R7 top code and out-of-range code
    src_i = 32'h0000_0300; wr(3'd4, 32'h0000_0076); settle();
    chk("R7 code6/7", 32'(irq_o), 32'b10_0000);
    wr(3'd4, 32'h0000_00F9); settle(); chk("R7 high codes", 32'(irq_o), 0);

    // R8 mask gates
    wr(3'd4, 32'h0000_0011); settle(); chk("R8 on", 32'(irq_o), 1);
    wr(3'd0, 32'hFFFF_FCFF); settle(); chk("R8 masked", 32'(irq_o), 0);
    wr(3'd0, 32'hFFFF_FFFF); settle();

    // R9 shared output, drop one source
    src_i = 32'h0000_0100; settle(); chk("R9 one left", 32'(irq_o), 1);
    src_i = 32'h0; settle(); chk("R9 none", 32'(irq_o), 0);

    // R10 write latency
    src_i = 32'h0000_0100; settle();
    wr(3'd4, 32'h0000_0022); chk("R10 wr before", 32'(irq_o), 1);
    @(negedge clk); chk("R10 wr after", 32'(irq_o), 2);
    // R10 source latency
    src_i = 32'h0;
    @(negedge clk); chk("R10 src e1", 32'(irq_o), 2);
    @(negedge clk); chk("R10 src e2", 32'(irq_o), 2);
    @(negedge clk); chk("R10 src e3", 32'(irq_o), 0);

    // R11 unmapped words
    wr(3'd6, 32'hDEAD_BEEF); wr(3'd7, 32'hCAFE_F00D);
    rd(3'd6, d); chk("R11 rd6", d, 0);
    rd(3'd7, d); chk("R11 rd7", d, 0);
    rd(3'd0, d); chk("R11 mask kept", d, 32'hFFFF_FFFF);
    for (int j = 0; j < 4; j++) begin rd(3'(2+j), d); chk("R11 route kept", d, exp_word(j)); end

    // random rounds, R4 R7 R8 R9
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) wr(3'd0, $urandom());
      else if (op == 1) wr(3'(2 + $urandom_range(0, 3)), $urandom());
      else if (op == 2) begin @(negedge clk); src_i = $urandom(); end
      else begin
        @(negedge clk); src_i = $urandom();
        wr(3'(2 + $urandom_range(0, 3)), $urandom());
      end
      settle();
      chk_irq("R9 random irq");
      rd(3'd1, d); chk("R3 random status", d, src_i);
      if (it % 8 == 0)
        for (int j = 0; j < 4; j++) begin rd(3'(2+j), d); chk("R4 random rb", d, exp_word(j)); end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule